// File: doc/BRIEF.md
# Nested Priority Interrupt Gate

This block sits between a set of interrupt sources and a processor core. Every source has its own request wire and its own acknowledge wire. Each request wire has a fixed, distinct level: line `i` counts as level `i+1`, and level 0 means that nothing is pending. The block keeps the processor's current priority level and its privilege mode. On every clock it looks for the most urgent pending request. It admits that request only when the request's level is strictly above the current level. The admitted source then receives a one-clock acknowledge.

Admission saves the current level and mode on an internal return stack. The current level then rises to the admitted level and the mode becomes supervisor. Because only requests above the new level get through, a more urgent source can still preempt the routine that is running, so service nests naturally. A return strobe takes the saved pair off the stack and restores it. Software may rewrite the level and mode through a status write, but only while in supervisor mode. A write attempted in user mode leaves the state untouched and produces a privilege-fault pulse instead.

Top module: `prio_nest_gate`

## Requirements
- R1: After reset, `curLevel` is 0, `supMode` is 1, and `irqAck`, `privFault` and `retUnderflow` are all 0.
- R2: Request bit `i` carries level `i+1`. Among simultaneous requests, only the highest level is admitted. Admission shows as a single-clock pulse on `irqAck[i]` in the cycle after the request is sampled, and at most one acknowledge bit is ever high.
- R3: A request is admitted only if its level is strictly greater than `curLevel`. A request at the current level or below gets no acknowledge and leaves the state unchanged.
- R4: While `intEnable` is 0, no request is admitted.
- R5: On admission, the previous level and mode are pushed onto the stack, `curLevel` becomes the admitted level and `supMode` becomes 1. All three changes appear in the same cycle as the acknowledge.
- R6: A request whose level is above a level that was itself reached by admission is admitted as well, so service nests.
- R7: A status write (`psWrEn`) in supervisor mode loads `psWrLevel` into `curLevel` and `psWrMode` into `supMode`, visible in the next cycle.
- R8: A status write in user mode changes neither level nor mode, and pulses `privFault` for one cycle.
- R9: `retIntr` pops the stack and restores the saved level and mode in the next cycle.
- R10: `retIntr` with an empty stack changes nothing and pulses `retUnderflow` for one cycle.
- R11: While the stack holds `STACK_DEPTH` entries, no request is admitted.
- R12: Only one action takes effect per cycle, in this order: return, then admission, then status write. A status write that loses this contest has no effect and raises no fault, and no acknowledge is issued in a return cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irqReq | input | NUM_LINES | Per-source request lines; bit i is level i+1 |
| intEnable | input | 1 | Global admission enable |
| psWrEn | input | 1 | Status write strobe |
| psWrLevel | input | LVL_W | Level value carried by a status write |
| psWrMode | input | 1 | Mode value carried by a status write (1 = supervisor) |
| retIntr | input | 1 | Return-from-service strobe |
| irqAck | output | NUM_LINES | Per-source acknowledge, one-clock pulse |
| curLevel | output | LVL_W | Current processor priority level |
| supMode | output | 1 | Current mode, 1 = supervisor |
| privFault | output | 1 | Pulse on a status write attempted in user mode |
| retUnderflow | output | 1 | Pulse on a return with an empty stack |

## Verification
The bench builds the block with its defaults: seven request lines, a 3-bit level field and a seven-deep return stack. With these values, every level from 1 to 7 can be exercised. The full stack is reachable in a short run: supervisor writes that drop the level back to 0 are alternated with level-1 admissions. A reference model that follows the requirements predicts each cycle, and covers ties, equal-level refusals, user-mode faults and the contests between a return, an admission and a status write in the same cycle.

// File: rtl/prio_nest_pkg.sv
package prio_nest_pkg;
  // Strobes issued by the control unit to the datapath for one cycle.
  typedef struct packed {
    logic push;       // admit the best request, save state
    logic pop;        // restore saved state
    logic wrPs;       // load level and mode from a status write
    logic fault;      // user-mode status write attempt
    logic underflow;  // return with nothing saved
  } nest_strobe_t;
endpackage

// File: rtl/prio_nest_ctrl.sv
module prio_nest_ctrl
  import prio_nest_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             retIntr,
  input  logic             intEnable,
  input  logic             psWrEn,
  input  logic [LVL_W-1:0] bestLvl,
  input  logic [LVL_W-1:0] curLevel,
  input  logic             supMode,
  input  logic             stackEmpty,
  input  logic             stackFull,
  output nest_strobe_t     strobe
);
  logic admit;

  // Return outranks admission, and admission outranks a status write.
  assign admit = !retIntr && intEnable && (bestLvl > curLevel) && !stackFull;

  always_comb begin
    strobe           = '0;
    strobe.pop       = retIntr && !stackEmpty;
    strobe.underflow = retIntr && stackEmpty;
    strobe.push      = admit;
    strobe.wrPs      = !retIntr && !admit && psWrEn && supMode;
    strobe.fault     = !retIntr && !admit && psWrEn && !supMode;
  end
endmodule

// File: rtl/prio_nest_dp.sv
module prio_nest_dp
  import prio_nest_pkg::*;
#(
  parameter int NUM_LINES   = 7,
  parameter int STACK_DEPTH = 7,
  parameter int LVL_W       = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irqReq,
  input  logic [LVL_W-1:0]     psWrLevel,
  input  logic                 psWrMode,
  input  nest_strobe_t         strobe,
  output logic [LVL_W-1:0]     bestLvl,
  output logic [LVL_W-1:0]     curLevel,
  output logic                 supMode,
  output logic                 stackEmpty,
  output logic                 stackFull,
  output logic [NUM_LINES-1:0] irqAck,
  output logic                 privFault,
  output logic                 retUnderflow
);
  localparam int SP_W  = $clog2(STACK_DEPTH + 1);
  localparam int IDX_W = $clog2(STACK_DEPTH);

  logic [LVL_W-1:0]     lvlStk  [STACK_DEPTH];
  logic                 modeStk [STACK_DEPTH];
  logic [SP_W-1:0]      sp;
  logic [IDX_W-1:0]     pushIdx;
  logic [IDX_W-1:0]     popIdx;
  logic [NUM_LINES-1:0] ackNext;

  // Highest-numbered pending line wins; its level is index + 1.
  always_comb begin
    bestLvl = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (irqReq[i]) bestLvl = LVL_W'(i + 1);
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_ack
    assign ackNext[g] = strobe.push && (bestLvl == LVL_W'(g + 1));
  end

  assign stackEmpty = (sp == '0);
  assign stackFull  = (sp == SP_W'(STACK_DEPTH));
  assign pushIdx    = IDX_W'(sp);
  assign popIdx     = IDX_W'(sp - 1'b1);

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      lvlStk[pushIdx]  <= curLevel;
      modeStk[pushIdx] <= supMode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curLevel     <= '0;
      supMode      <= 1'b1;
      sp           <= '0;
      irqAck       <= '0;
      privFault    <= 1'b0;
      retUnderflow <= 1'b0;
    end else begin
      irqAck       <= ackNext;
      privFault    <= strobe.fault;
      retUnderflow <= strobe.underflow;
      if (strobe.pop) begin
        curLevel <= lvlStk[popIdx];
        supMode  <= modeStk[popIdx];
        sp       <= sp - 1'b1;
      end else if (strobe.push) begin
        curLevel <= bestLvl;
        supMode  <= 1'b1;
        sp       <= sp + 1'b1;
      end else if (strobe.wrPs) begin
        curLevel <= psWrLevel;
        supMode  <= psWrMode;
      end
    end
  end
endmodule

// File: rtl/prio_nest_gate.sv
module prio_nest_gate
  import prio_nest_pkg::*;
#(
  parameter int NUM_LINES   = 7,
  parameter int STACK_DEPTH = NUM_LINES,
  parameter int LVL_W       = $clog2(NUM_LINES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irqReq,
  input  logic                 intEnable,
  input  logic                 psWrEn,
  input  logic [LVL_W-1:0]     psWrLevel,
  input  logic                 psWrMode,
  input  logic                 retIntr,
  output logic [NUM_LINES-1:0] irqAck,
  output logic [LVL_W-1:0]     curLevel,
  output logic                 supMode,
  output logic                 privFault,
  output logic                 retUnderflow
);
  nest_strobe_t     strobe;
  logic [LVL_W-1:0] bestLvl;
  logic             stackEmpty;
  logic             stackFull;

  prio_nest_ctrl #(.LVL_W(LVL_W)) ctrl_i (
    .retIntr    (retIntr),
    .intEnable  (intEnable),
    .psWrEn     (psWrEn),
    .bestLvl    (bestLvl),
    .curLevel   (curLevel),
    .supMode    (supMode),
    .stackEmpty (stackEmpty),
    .stackFull  (stackFull),
    .strobe     (strobe)
  );

  prio_nest_dp #(
    .NUM_LINES   (NUM_LINES),
    .STACK_DEPTH (STACK_DEPTH),
    .LVL_W       (LVL_W)
  ) dp_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .irqReq       (irqReq),
    .psWrLevel    (psWrLevel),
    .psWrMode     (psWrMode),
    .strobe       (strobe),
    .bestLvl      (bestLvl),
    .curLevel     (curLevel),
    .supMode      (supMode),
    .stackEmpty   (stackEmpty),
    .stackFull    (stackFull),
    .irqAck       (irqAck),
    .privFault    (privFault),
    .retUnderflow (retUnderflow)
  );
endmodule

// File: rtl/prio_nest_chk.sv
module prio_nest_chk #(
  parameter int NUM_LINES = 7,
  parameter int LVL_W     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] irqReq,
  input logic                 intEnable,
  input logic                 psWrEn,
  input logic                 retIntr,
  input logic [NUM_LINES-1:0] irqAck,
  input logic [LVL_W-1:0]     curLevel,
  input logic                 supMode,
  input logic                 privFault,
  input logic                 retUnderflow
);
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irqAck)); // R2

  AST_ACK_HAD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|irqAck) |-> ((irqAck & $past(irqReq)) == irqAck)); // R2

  AST_ACK_OUTRANKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|irqAck) |-> (curLevel > $past(curLevel))); // R3

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_lvl
    AST_ACK_LEVEL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      irqAck[g] |-> (supMode && (curLevel == LVL_W'(g + 1)))); // R5
  end

  AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !intEnable |=> (irqAck == '0)); // R4

  AST_FAULT_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    privFault |-> ((curLevel == $past(curLevel)) && !supMode)); // R8

  AST_FAULT_NEEDS_USER: assert property (@(posedge clk) disable iff (!rst_n)
    privFault |-> ($past(psWrEn) && !$past(supMode))); // R8

  AST_UNDERFLOW_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    retUnderflow |-> ((curLevel == $past(curLevel)) && (supMode == $past(supMode)))); // R10

  AST_RETURN_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    retIntr |=> (irqAck == '0)); // R12
endmodule

bind prio_nest_gate prio_nest_chk #(
  .NUM_LINES (NUM_LINES),
  .LVL_W     (LVL_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .irqReq       (irqReq),
  .intEnable    (intEnable),
  .psWrEn       (psWrEn),
  .retIntr      (retIntr),
  .irqAck       (irqAck),
  .curLevel     (curLevel),
  .supMode      (supMode),
  .privFault    (privFault),
  .retUnderflow (retUnderflow)
);

// File: tb/prio_nest_gate_tb_top.sv
`timescale 1ns/1ps
module prio_nest_gate_tb_top;
  localparam int NL = 7;
  localparam int LW = 3;
  localparam int SD = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] irqReq = '0;
  logic          intEnable = 1'b0;
  logic          psWrEn = 1'b0;
  logic [LW-1:0] psWrLevel = '0;
  logic          psWrMode = 1'b0;
  logic          retIntr = 1'b0;
  logic [NL-1:0] irqAck;
  logic [LW-1:0] curLevel;
  logic          supMode;
  logic          privFault;
  logic          retUnderflow;

  int checks = 0;
  int errors = 0;
  int cycCount = 0;
  bit done = 1'b0;

  typedef struct {
    int            cyc;
    logic [NL-1:0] ack;
    logic [LW-1:0] lvl;
    logic          mode;
    logic          fault;
    logic          uf;
    string         tag;
  } exp_t;

  exp_t expQ[$];

  // Reference state built from the requirements.
  logic [LW-1:0] mLvl = '0;
  logic          mMode = 1'b1;
  logic [LW-1:0] mStkLvl[$];
  logic          mStkMode[$];

  always #2 clk = ~clk;

  prio_nest_gate dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .irqReq       (irqReq),
    .intEnable    (intEnable),
    .psWrEn       (psWrEn),
    .psWrLevel    (psWrLevel),
    .psWrMode     (psWrMode),
    .retIntr      (retIntr),
    .irqAck       (irqAck),
    .curLevel     (curLevel),
    .supMode      (supMode),
    .privFault    (privFault),
    .retUnderflow (retUnderflow)
  );

  always @(posedge clk) cycCount <= cycCount + 1;

  // Monitor: compare the expected items due in this cycle.
  always @(negedge clk) begin
    exp_t e;
    while (expQ.size() > 0 && expQ[0].cyc == cycCount) begin
      e = expQ.pop_front();
      checks++;
      if (irqAck !== e.ack || curLevel !== e.lvl || supMode !== e.mode ||
          privFault !== e.fault || retUnderflow !== e.uf) begin
        errors++;
        $display("FAIL %s: ack=%b/%b lvl=%0d/%0d mode=%b/%b fault=%b/%b uf=%b/%b (actual/expected)",
                 e.tag, irqAck, e.ack, curLevel, e.lvl, supMode, e.mode,
                 privFault, e.fault, retUnderflow, e.uf);
      end
    end
  end

  // Driver: apply one cycle of stimulus and queue the predicted outcome.
  task automatic step(input logic [NL-1:0] req, input logic en, input logic wr,
                      input logic [LW-1:0] wl, input logic wm, input logic ret,
                      input string tag);
    exp_t e;
    logic [LW-1:0] best;
    @(negedge clk);
    irqReq = req; intEnable = en; psWrEn = wr; psWrLevel = wl;
    psWrMode = wm; retIntr = ret;
    e.cyc = cycCount + 1; e.ack = '0; e.fault = 1'b0; e.uf = 1'b0; e.tag = tag;
    best = '0;
    for (int i = 0; i < NL; i++) if (req[i]) best = LW'(i + 1);
    if (ret) begin
      if (mStkLvl.size() == 0) e.uf = 1'b1;
      else begin
        mLvl = mStkLvl.pop_back();
        mMode = mStkMode.pop_back();
      end
    end else if (en && best > mLvl && mStkLvl.size() < SD) begin
      mStkLvl.push_back(mLvl);
      mStkMode.push_back(mMode);
      mLvl = best; mMode = 1'b1;
      e.ack[best - 1] = 1'b1;
    end else if (wr) begin
      if (mMode) begin mLvl = wl; mMode = wm; end
      else e.fault = 1'b1;
    end
    e.lvl = mLvl; e.mode = mMode;
    expQ.push_back(e);
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (irqAck !== '0 || curLevel !== '0 || supMode !== 1'b1 ||
        privFault !== 1'b0 || retUnderflow !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: ack=%b lvl=%0d mode=%b fault=%b uf=%b expected 0/0/1/0/0",
               irqAck, curLevel, supMode, privFault, retUnderflow);
    end

    step(7'b0001000, 1, 0, 0, 0, 0, "R2 R5 single line3 level4");
    step(7'b0000000, 1, 0, 0, 0, 0, "R2 ack lasts one cycle");
    step(7'b0000010, 1, 0, 0, 0, 0, "R3 lower level refused");
    step(7'b0001000, 1, 0, 0, 0, 0, "R3 equal level refused");
    step(7'b1100000, 1, 0, 0, 0, 0, "R2 R6 tie picks level7 nested");
    step(7'b0000000, 1, 0, 0, 0, 1, "R9 return to level4");
    step(7'b0000000, 1, 0, 0, 0, 1, "R9 return to level0");
    step(7'b0000000, 1, 0, 0, 0, 1, "R10 empty return");
    step(7'b1111111, 0, 0, 0, 0, 0, "R4 disabled blocks all");
    step(7'b0000000, 1, 1, 3'd2, 0, 0, "R7 supervisor write level2 user");
    step(7'b0000000, 1, 1, 3'd5, 1, 0, "R8 user write faults");
    step(7'b0000001, 1, 0, 0, 0, 0, "R3 level1 below level2");
    step(7'b0000100, 1, 0, 0, 0, 0, "R5 user preempted to supervisor");
    step(7'b0000000, 1, 0, 0, 0, 1, "R9 restores user mode");
    step(7'b0010000, 1, 0, 0, 0, 0, "R6 admit level5");
    step(7'b1000000, 1, 0, 0, 0, 1, "R12 return beats admission");
    step(7'b1000000, 1, 1, 3'd1, 0, 0, "R12 admission beats user write");
    step(7'b0000000, 1, 0, 0, 0, 1, "R9 unwind");
    step(7'b1000000, 1, 0, 0, 0, 0, "R5 admit level7");
    for (int k = 0; k < SD - 1; k++) begin
      step(7'b0000000, 1, 1, 3'd0, 1, 0, "R7 drop level to 0");
      step(7'b0000001, 1, 0, 0, 0, 0, "R11 push toward full");
    end
    step(7'b0000000, 1, 1, 3'd0, 1, 0, "R7 drop level at full");
    step(7'b0000001, 1, 0, 0, 0, 0, "R11 full stack blocks");
    for (int k = 0; k < SD + 1; k++) begin
      step(7'b0000000, 1, 0, 0, 0, 1, "R9 R10 unwind full stack");
    end
    step(7'b0000000, 1, 0, 0, 0, 0, "R1 idle tail");
    repeat (3) @(negedge clk);
    done = 1'b1;
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      finishRun();
    end
  end
endmodule